// File: doc/BRIEF.md
# Field-Synchronized Double-Buffered Base Address Bank

This block holds a small set of 32-bit memory base addresses used by a video capture DMA engine. Software may rewrite any base address at any moment. The address the DMA engine sees must stay fixed for a whole field, because a mid-field switch would split one field across two buffers. Each entry therefore has two copies. A host write lands in a staging copy. A live copy drives the DMA engine.

A single-cycle `field_start` pulse marks the capture of the first data of a new field. On that pulse, every staging value is copied into its live copy in the same cycle. A shared "not updated" flag in a status word tells software that staged values have not yet been applied. Any write sets the flag, and the transfer clears it.

A readback port lets the host view either copy of any entry. Bus decoding and the DMA engine itself sit outside this block.

Top module: `dbuf_base_bank`

## Requirements
- R1: After reset, every staging copy and every live copy reads zero, and the status word is zero.
- R2: A host write changes only the staging copy of the selected entry. The live copies keep their values until a `field_start` pulse.
- R3: One cycle after any host write, bit 16 of `status_word` reads 1. All other status bits always read 0.
- R4: One cycle after a `field_start` pulse, every live copy equals the value its staging copy held before that edge. All entries change in the same cycle.
- R5: A `field_start` pulse with no write in the same cycle clears status bit 16 one cycle later.
- R6: Bits [4:0] of a written value are stored as zero, so every stored address is 32-byte aligned.
- R7: When several writes to one entry occur within one field, only the last value is transferred at the next `field_start`.
- R8: When a write and `field_start` fall in the same cycle:
  - the live copy takes the previous staging value;
  - the new value stays in the staging copy;
  - status bit 16 stays 1.
- R9: `rd_data` shows, combinationally, the staging copy of entry `rd_sel` when `rd_pending` is 1, and the live copy of that entry when `rd_pending` is 0.

Entry k occupies bits [32k+31:32k] of `active_bases`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Entry to write |
| wr_data | input | 32 | Address to stage |
| field_start | input | 1 | Pulse when the first data of a new field is captured |
| rd_sel | input | 2 | Entry to read back |
| rd_pending | input | 1 | 1 = read the staging copy, 0 = read the live copy |
| rd_data | output | 32 | Readback value |
| active_bases | output | 128 | Live addresses, packed one entry per 32 bits |
| status_word | output | 32 | Status word; bit 16 is the "not updated" flag |

## Verification
A host write and the field-start transfer can fall in the same clock cycle. That cycle decides both the staged contents and the flag.

The bench forces this collision in a directed case, then again many times in random traffic, where writes and field pulses are drawn independently. After each such cycle it checks three things against a bench model:
- the live copy holds the old staged value;
- the staging copy holds the new value;
- the flag is still set.

// File: rtl/dbuf_base_bank.sv
module dbuf_base_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ALIGN_W  = 5,
  parameter int FLAG_POS = 16,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       field_start,
  input  logic [SEL_W-1:0]           rd_sel,
  input  logic                       rd_pending,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] active_bases,
  output logic [DATA_W-1:0]          status_word
);

  logic [DATA_W-1:0] pend_q [NUM_REGS];
  logic [DATA_W-1:0] act_q  [NUM_REGS];
  logic              stale_q;

  wire [DATA_W-1:0] wr_aligned = {wr_data[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= '0;
        act_q[i]  <= '0;
      end else begin
        if (wr_en && wr_sel == SEL_W'(i)) pend_q[i] <= wr_aligned;
        if (field_start)                  act_q[i]  <= pend_q[i];
      end
    end
    assign active_bases[i*DATA_W +: DATA_W] = act_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           stale_q <= 1'b0;
    else if (wr_en)       stale_q <= 1'b1;
    else if (field_start) stale_q <= 1'b0;
  end

  assign status_word = {{(DATA_W-1){1'b0}}, stale_q} << FLAG_POS;
  assign rd_data     = rd_pending ? pend_q[rd_sel] : act_q[rd_sel];

endmodule

module dbuf_base_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ALIGN_W  = 5,
  parameter int FLAG_POS = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       field_start,
  input logic [NUM_REGS*DATA_W-1:0] active_bases,
  input logic [DATA_W-1:0]          status_word
);

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status_word[FLAG_POS]);

  assert_other_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_word) <= 1 && (status_word[FLAG_POS] || status_word == '0));

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !wr_en) |=> !status_word[FLAG_POS]);

  assert_collide_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && wr_en) |=> status_word[FLAG_POS]);

  assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(active_bases));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_align
    assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active_bases[i*DATA_W +: ALIGN_W] == '0);
  end

endmodule

bind dbuf_base_bank dbuf_base_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ALIGN_W(ALIGN_W), .FLAG_POS(FLAG_POS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .field_start(field_start),
  .active_bases(active_bases), .status_word(status_word)
);

// File: tb/dbuf_base_bank_test.sv
module dbuf_base_bank_test;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, field_start = 0, rd_pending = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data, status_word;
  logic [N*32-1:0] active_bases;

  int total = 0, bad = 0;
  logic [31:0] m_pend [N];
  logic [31:0] m_act  [N];
  logic m_flag;

  always #5 clk = ~clk;

  dbuf_base_bank uut (.*);

  function automatic logic [31:0] align(input logic [31:0] v);
    return {v[31:5], 5'b0};
  endfunction

  function automatic logic [31:0] exp_status(input logic f);
    return f ? 32'h0001_0000 : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_sel = 2'(i);
      rd_pending = 1; #1;
      chk({req, " R9 pending"}, rd_data, m_pend[i]);
      rd_pending = 0; #1;
      chk({req, " R9 live"}, rd_data, m_act[i]);
      chk({req, " R4 live bus"}, active_bases[i*32 +: 32], m_act[i]);
    end
    chk({req, " R3 status"}, status_word, exp_status(m_flag));
  endtask

  task automatic step(input logic w, input logic [1:0] s, input logic [31:0] d, input logic f);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_data = d; field_start = f;
    @(posedge clk);
    if (f) for (int i = 0; i < N; i++) m_act[i] = m_pend[i];
    if (w) m_pend[s] = align(d);
    m_flag = w ? 1'b1 : (f ? 1'b0 : m_flag);
    #2;
    wr_en = 0; field_start = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_all("R1 reset");

    step(1, 2'd1, 32'hDEAD_BEEF, 0);
    check_all("R2 R6 write parked");
    step(1, 2'd1, 32'h1234_567F, 0);
    step(1, 2'd3, 32'hFFFF_FFFF, 0);
    check_all("R7 rewrite");
    step(0, 0, 0, 1);
    check_all("R4 R5 R7 transfer");
    step(1, 2'd2, 32'hA5A5_A5A5, 1);
    check_all("R8 collision");
    step(0, 0, 0, 1);
    check_all("R5 R8 follow-up");

    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 3) == 0, 2'($urandom), $urandom, ($urandom % 6) == 0);
      check_all("random R2 R4 R8");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule